// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address presented to a synchronous burst memory array. A burst opens when either of two start strobes is seen on a rising clock edge. One strobe comes from the processor side and counts only when the chip-select condition holds in the same cycle. The other comes from the controller side and always counts. Either strobe captures the external address. After that, the two least significant address bits are generated inside the block. They step through a group of four beats, one beat for each cycle in which the advance input is high.

The beat order is chosen when the burst starts. In linear order the low bits count upward from the starting value, modulo four. In interleaved order the low bits are the starting value XOR the beat number. The order input has interleaved as its high level, which is the level an on-pad pull-up gives when the input is left floating. Bursting is optional: a fresh external address may be captured on every cycle. All inputs are sampled on the rising edge, and both outputs come straight from flops.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous reset, cur_addr is 0 and beat_idx is 0, and no burst is open. While no burst is open, advance has no effect.
- R2: When ctl_start is high at a rising edge, cur_addr equals ext_addr and beat_idx equals 0 after that edge.
- R3: When cpu_start and chip_sel are both high at a rising edge, ext_addr is captured in the same way as in R2.
- R4: When cpu_start is high, chip_sel is low and neither ctl_start nor advance is high, the edge changes neither cur_addr nor beat_idx.
- R5: During an open burst, each edge with advance high and no start adds 1 to beat_idx, modulo 4. An edge with advance low leaves both outputs unchanged.
- R6: In linear order (order_ilv captured as 0), the low two bits of cur_addr equal (start low bits + beat_idx) mod 4.
- R7: In interleaved order (order_ilv captured as 1, the pull-up level), the low two bits equal start low bits XOR beat_idx. The order is captured at the start edge and held for the rest of the burst.
- R8: The bits of cur_addr above bit 1 hold their captured value for the whole burst. After four advances, beat_idx returns to 0 and the low bits return to the start value.
- R9: When a start and advance are high at the same edge, the start wins: the new address is captured and beat_idx becomes 0.
- R10: Starts on consecutive edges each capture their own address, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External address captured on a start |
| cpu_start | input | 1 | Processor-side burst start, qualified by chip_sel |
| chip_sel | input | 1 | Chip-select condition for cpu_start |
| ctl_start | input | 1 | Controller-side burst start, unqualified |
| advance | input | 1 | Step to the next beat |
| order_ilv | input | 1 | 1 = interleaved order (pull-up level), 0 = linear |
| cur_addr | output | ADDR_W | Current word address |
| beat_idx | output | 2 | Beat number within the burst |

## Verification
Both results take a single register stage. A start or an advance sampled at a rising edge is visible on cur_addr and beat_idx once that edge has passed, and they stay there until the next edge. The bench changes the inputs on the falling edge and reads the outputs 2 ns after the rising edge that consumed them. Each row of the vector table therefore holds the outputs due after exactly one edge. The directed reset checks follow the same one-edge rule.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;

  function automatic beat_t beat_low(input beat_t start, input beat_t beat, input order_e ord);
    beat_t r;
    if (ord == ORD_INTERLEAVE) r = start ^ beat;
    else r = start + beat;
    return r;
  endfunction
endpackage

// File: rtl/burst_strobe_ctrl.sv
module burst_strobe_ctrl (
  input  logic cpu_start,
  input  logic chip_sel,
  input  logic ctl_start,
  input  logic advance,
  input  logic active,
  output logic load,
  output logic step
);
  always_comb begin
    load = ctl_start | (cpu_start & chip_sel);
    step = advance & active & ~load;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  output beat_t beat_q,
  output logic  active_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      beat_q   <= '0;
      active_q <= 1'b1;
    end else if (step) begin
      beat_q   <= beat_q + beat_t'(1);
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (beat_q == '0 && !active_q));
  p_idle_stays_r1: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !load) |=> (!active_q && beat_q == '0));
  p_step_incr_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (beat_q == beat_t'($past(beat_q) + beat_t'(1))));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(beat_q));
  p_start_wins_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0 && active_q));
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              order_in,
  input  beat_t             beat,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0] hi_q;
  beat_t           lo_q;
  order_e          ord_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ord_q <= ORD_INTERLEAVE;
    end else if (load) begin
      hi_q  <= ext_addr[ADDR_W-1:BEAT_W];
      lo_q  <= ext_addr[BEAT_W-1:0];
      ord_q <= order_e'(order_in);
    end
  end

  always_comb cur_addr = {hi_q, beat_low(lo_q, beat, ord_q)};

  p_upper_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_addr == $past(ext_addr)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              cpu_start,
  input  logic              chip_sel,
  input  logic              ctl_start,
  input  logic              advance,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        beat_idx
);
  logic  load, step, active;
  beat_t beat;

  burst_strobe_ctrl u_ctrl (
    .cpu_start(cpu_start), .chip_sel(chip_sel), .ctl_start(ctl_start),
    .advance(advance), .active(active), .load(load), .step(step)
  );

  burst_beat_ctr u_ctr (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .beat_q(beat), .active_q(active)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk(clk), .rst(rst), .load(load), .ext_addr(ext_addr),
    .order_in(order_ilv), .beat(beat), .cur_addr(cur_addr)
  );

  assign beat_idx = beat;

  p_cpu_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_start && !chip_sel && !ctl_start && !advance) |=> ($stable(cur_addr) && $stable(beat_idx)));
  p_cpu_load_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_start && chip_sel) |=> (beat_idx == 2'd0 && cur_addr == $past(ext_addr)));
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 20;
  localparam int NV = 18;
  // {ctl, cpu, cs, adv, ilv, addr, exp_addr, exp_beat, req}
  localparam logic [50:0] VEC [NV] = '{
    {5'b10000, 20'h12345, 20'h12345, 2'd0, 4'd2},  // R2 controller start, linear
    {5'b00010, 20'h00000, 20'h12346, 2'd1, 4'd6},  // R6 linear step
    {5'b00010, 20'h00000, 20'h12347, 2'd2, 4'd6},  // R6
    {5'b00000, 20'h00000, 20'h12347, 2'd2, 4'd5},  // R5 hold without advance
    {5'b00010, 20'h00000, 20'h12344, 2'd3, 4'd6},  // R6 wrap of low bits
    {5'b00010, 20'h00000, 20'h12345, 2'd0, 4'd8},  // R8 back to start
    {5'b01101, 20'hABCDE, 20'hABCDE, 2'd0, 4'd3},  // R3 processor start, interleaved
    {5'b00011, 20'h00000, 20'hABCDF, 2'd1, 4'd7},  // R7
    {5'b00011, 20'h00000, 20'hABCDC, 2'd2, 4'd7},  // R7
    {5'b00011, 20'h00000, 20'hABCDD, 2'd3, 4'd7},  // R7
    {5'b00011, 20'h00000, 20'hABCDE, 2'd0, 4'd8},  // R8
    {5'b01000, 20'h00000, 20'hABCDE, 2'd0, 4'd4},  // R4 gated processor start
    {5'b10011, 20'h55557, 20'h55557, 2'd0, 4'd9},  // R9 start beats advance
    {5'b00010, 20'h00000, 20'h55556, 2'd1, 4'd7},  // R7 order held from start
    {5'b10000, 20'h00001, 20'h00001, 2'd0, 4'd10}, // R10
    {5'b10000, 20'h00002, 20'h00002, 2'd0, 4'd10}, // R10 back to back
    {5'b01100, 20'hFFFFF, 20'hFFFFF, 2'd0, 4'd3},  // R3
    {5'b00010, 20'h00000, 20'hFFFFC, 2'd1, 4'd8}   // R8 upper bits fixed
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          cpu_start = 1'b0, chip_sel = 1'b0, ctl_start = 1'b0, advance = 1'b0;
  logic          order_ilv = 1'b1;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat_idx;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .cpu_start(cpu_start),
    .chip_sel(chip_sel), .ctl_start(ctl_start), .advance(advance),
    .order_ilv(order_ilv), .cur_addr(cur_addr), .beat_idx(beat_idx)
  );

  task automatic check(input string req, input logic [AW-1:0] ea, input logic [1:0] eb);
    checks++;
    if (cur_addr !== ea || beat_idx !== eb) begin
      errors++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d", req, cur_addr, beat_idx, ea, eb);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    {ctl_start, cpu_start, chip_sel, advance, order_ilv} = c;
    ext_addr = a;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset state", '0, 2'd0);
    @(negedge clk) rst = 1'b0;
    drive(5'b00010, 20'h00000);
    check("R1 advance before any start", '0, 2'd0);
    drive(5'b00010, 20'h00000);
    check("R1 advance before any start", '0, 2'd0);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][50:46], VEC[i][45:26]);
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), VEC[i][25:6], VEC[i][5:4]);
    end
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset mid-burst", '0, 2'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule